// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a synthesizable model of a 32-bit synchronous static RAM. Its inputs and outputs both pass through registers. On each rising clock edge, an input stage registers the chip select, address, write controls and write data. On the next edge the byte lanes either write the selected bytes or load the addressed word into an output register. The data for a read therefore appears one cycle after its address was sampled, and a read-valid flag marks it.

Writes can be restricted to single bytes. A global write strobe overrides all of the per-byte qualifiers and writes the whole word. The shared data bus is split into an input word, an output word and a drive flag. The drive flag reports when the pins would be actively driven.

The output-enable input is asynchronous and active low. It gates the drive flag, except on the first read after the part has been deselected, where it is ignored. A sleep input freezes activity and leaves the stored data intact. The memory depth is set by a parameter.

Top module: `sync_sram_pipe`

## Requirements
- R1: A read (cs_n_i=0, gw_n_i=1, bwe_n_i=1, sleep_i=0) sampled at edge k sets rvalid_o and presents the addressed word on rdata_o after edge k+1.
- R2: With gw_n_i=0 and cs_n_i=0, all four bytes of the addressed word are written, whatever bwe_n_i and bsel_n_i are.
- R3: With gw_n_i=1 and bwe_n_i=0, byte b (bits 8b+7 down to 8b) is written only when bsel_n_i[b]=0. All other bytes keep their old contents.
- R4: A write cycle with bwe_n_i=0 and every bsel_n_i bit high leaves memory unchanged. A write cycle never raises rvalid_o.
- R5: A cycle with cs_n_i=1 is a deselect. It performs no access, and rvalid_o is low after the second following edge.
- R6: drive_o is high only while rvalid_o is high and oe_n_i is low. oe_n_i acts without a clock edge.
- R7: The first read after a deselect cycle, or after reset, has drive_o low even when oe_n_i is low. The next read after it drives normally.
- R8: While sleep_i=1, presented accesses are ignored and rvalid_o is forced low on the next edge. Stored contents survive sleep.
- R9: Synchronous reset clears rvalid_o, drive_o and rdata_o and puts the block in the deselected state. Memory contents are not cleared.
- R10: A read in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep request, active high |
| cs_n_i | input | 1 | Chip select, active low |
| addr_i | input | ADDR_W | Word address |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte write enable, active low |
| bsel_n_i | input | BYTES | Per-byte select, active low, bit b for byte b |
| wdata_i | input | BYTES*BYTE_W | Write data |
| oe_n_i | input | 1 | Output enable, asynchronous, active low |
| rdata_o | output | BYTES*BYTE_W | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| drive_o | output | 1 | Data pins would be driven |

## Verification
The bound checker runs on every cycle. It covers read timing, the absence of a valid flag after write and deselect cycles, the forced drop of the valid flag in sleep, the gating of the drive flag by output enable, the masking after a deselect, and the reset state. Data content cannot be expressed that way. Per-byte merging, the global-write override, no-byte writes, write-then-read forwarding, and retention of contents across sleep and reset are shown only by the bench, which compares every read against its own byte-masked reference array.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  localparam int DEF_ADDR_W = 6;
  localparam int DEF_BYTES  = 4;
  localparam int DEF_BYTE_W = 8;

  // Byte lane write decision: global write wins, otherwise enable and select.
  function automatic logic lane_write(input logic gw_n, input logic bwe_n,
                                      input logic bsel_n);
    return !gw_n || (!bwe_n && !bsel_n);
  endfunction
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BYTES  = DEF_BYTES,
  parameter int BYTE_W = DEF_BYTE_W,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              cs_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [BYTES-1:0]  bsel_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [BYTES-1:0]  we_q,
  output logic              rd_q,
  output logic              mask_q
);
  logic             live;
  logic             is_wr;
  logic [BYTES-1:0] we_d;
  logic             desel_q;

  assign live  = !cs_n_i && !sleep_i;
  assign is_wr = !gw_n_i || !bwe_n_i;

  for (genvar b = 0; b < BYTES; b++) begin : g_we
    assign we_d[b] = live && lane_write(gw_n_i, bwe_n_i, bsel_n_i[b]);
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr_i;
    wdata_q <= wdata_i;
    if (rst) begin
      we_q    <= '0;
      rd_q    <= 1'b0;
      mask_q  <= 1'b0;
      desel_q <= 1'b1;
    end else begin
      we_q   <= we_d;
      rd_q   <= live && !is_wr;
      mask_q <= live && !is_wr && desel_q;
      if (!sleep_i) desel_q <= cs_n_i;
    end
  end
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] rq
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= mem[addr];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic rd_q,
  input  logic mask_q,
  input  logic oe_n_i,
  output logic rvalid_o,
  output logic drive_o
);
  logic valid_r;
  logic mask_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= 1'b0;
      mask_r  <= 1'b0;
    end else begin
      valid_r <= rd_q && !sleep_i;
      mask_r  <= mask_q;
    end
  end

  assign rvalid_o = valid_r;
  assign drive_o  = valid_r && !mask_r && !oe_n_i;
endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BYTES  = DEF_BYTES,
  parameter int BYTE_W = DEF_BYTE_W,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              cs_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [BYTES-1:0]  bsel_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              drive_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BYTES-1:0]  we_q;
  logic              rd_q;
  logic              mask_q;

  sram_in_stage #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_in (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .cs_n_i(cs_n_i),
    .addr_i(addr_i), .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i),
    .bsel_n_i(bsel_n_i), .wdata_i(wdata_i),
    .addr_q(addr_q), .wdata_q(wdata_q), .we_q(we_q),
    .rd_q(rd_q), .mask_q(mask_q)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    sram_byte_lane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_lane (
      .clk(clk), .rst(rst), .we(we_q[b]), .re(rd_q), .addr(addr_q),
      .wd(wdata_q[b*BYTE_W +: BYTE_W]),
      .rq(rdata_o[b*BYTE_W +: BYTE_W])
    );
  end

  sram_out_stage u_out (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .rd_q(rd_q),
    .mask_q(mask_q), .oe_n_i(oe_n_i),
    .rvalid_o(rvalid_o), .drive_o(drive_o)
  );
endmodule

// File: rtl/sync_sram_pipe_checker.sv
module sync_sram_pipe_checker (
  input logic clk,
  input logic rst,
  input logic sleep_i,
  input logic cs_n_i,
  input logic gw_n_i,
  input logic bwe_n_i,
  input logic oe_n_i,
  input logic rvalid_o,
  input logic drive_o
);
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_i && gw_n_i && bwe_n_i && !sleep_i) ##1 !sleep_i |=> rvalid_o); // R1

  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_i && (!gw_n_i || !bwe_n_i)) |=> ##1 !rvalid_o); // R4

  AST_DESEL_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> ##1 !rvalid_o); // R5

  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (rst)
    drive_o |-> (rvalid_o && !oe_n_i)); // R6

  AST_FIRST_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i && !sleep_i) ##1 (!cs_n_i && gw_n_i && bwe_n_i && !sleep_i) ##1 !sleep_i
    |=> !drive_o); // R7

  AST_SLEEP_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !rvalid_o); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!rvalid_o && !drive_o)); // R9
endmodule

bind sync_sram_pipe sync_sram_pipe_checker u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .cs_n_i(cs_n_i),
  .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .oe_n_i(oe_n_i),
  .rvalid_o(rvalid_o), .drive_o(drive_o)
);

// File: tb/sync_sram_pipe_bench.sv
module sync_sram_pipe_bench;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int N  = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_i = 1'b0;
  logic          cs_n_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          gw_n_i = 1'b1;
  logic          bwe_n_i = 1'b1;
  logic [3:0]    bsel_n_i = 4'hF;
  logic [DW-1:0] wdata_i = '0;
  logic          oe_n_i = 1'b1;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;
  logic          drive_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sync_sram_pipe u_sync_sram_pipe (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .cs_n_i(cs_n_i),
    .addr_i(addr_i), .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i),
    .bsel_n_i(bsel_n_i), .wdata_i(wdata_i), .oe_n_i(oe_n_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .drive_o(drive_o)
  );

  typedef struct packed {
    logic          cs_n;
    logic          gw_n;
    logic          bwe_n;
    logic [3:0]    bsel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          oe_n;
    logic          ev;
    logic          ed;
  } vec_t;

  // cs_n gw_n bwe_n bsel_n addr wdata oe_n exp_valid exp_drive
  localparam vec_t TBL [N] = '{
    '{1'b0, 1'b0, 1'b1, 4'hF, 6'd3, 32'hA5A5_5A5A, 1'b0, 1'b0, 1'b0}, // R2 full write
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd3, 32'h0,         1'b0, 1'b1, 1'b1}, // R1 R10 read
    '{1'b0, 1'b1, 1'b0, 4'hE, 6'd3, 32'h0000_00FF, 1'b0, 1'b0, 1'b0}, // R3 byte 0
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd3, 32'h0,         1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 4'hF, 6'd3, 32'h1111_1111, 1'b0, 1'b0, 1'b0}, // R4 no byte
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd3, 32'h0,         1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b0, 4'hF, 6'd5, 32'h1234_5678, 1'b0, 1'b0, 1'b0}, // R2 override
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd0, 32'h0,         1'b0, 1'b0, 1'b0}, // R5 deselect
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd3, 32'h0,         1'b0, 1'b1, 1'b0}, // R7 masked
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0,         1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0,         1'b1, 1'b1, 1'b0}, // R6 oe high
    '{1'b0, 1'b1, 1'b0, 4'h5, 6'd5, 32'hFFEE_DDCC, 1'b0, 1'b0, 1'b0}, // R3 bytes 1,3
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0,         1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd3, 32'h0,         1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd0, 32'h0,         1'b0, 1'b0, 1'b0}  // R5
  };

  logic [DW-1:0] ref_mem [1 << AW];
  logic [DW-1:0] exp_data [N];

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_op(input logic cs_n, input logic gw_n, input logic bwe_n,
                        input logic [3:0] bsel_n, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd);
    cs_n_i = cs_n; gw_n_i = gw_n; bwe_n_i = bwe_n;
    bsel_n_i = bsel_n; addr_i = addr; wdata_i = wd;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    oe_n_i = 1'b0;
    #1;
    check("R9 reset rvalid", {31'b0, rvalid_o}, 32'h0);
    check("R9 reset drive", {31'b0, drive_o}, 32'h0);
    check("R9 reset rdata", rdata_o, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        oe_n_i = TBL[i-2].oe_n;
        #1;
        check($sformatf("R1/R5 valid op%0d", i-2), {31'b0, rvalid_o},
              {31'b0, TBL[i-2].ev});
        check($sformatf("R6/R7 drive op%0d", i-2), {31'b0, drive_o},
              {31'b0, TBL[i-2].ed});
        if (TBL[i-2].ev)
          check($sformatf("R2/R3/R4/R10 data op%0d", i-2), rdata_o, exp_data[i-2]);
      end
      if (i < N) begin
        set_op(TBL[i].cs_n, TBL[i].gw_n, TBL[i].bwe_n, TBL[i].bsel_n,
               TBL[i].addr, TBL[i].wd);
        exp_data[i] = '0;
        if (!TBL[i].cs_n) begin
          if (!TBL[i].gw_n) ref_mem[TBL[i].addr] = TBL[i].wd;
          else if (!TBL[i].bwe_n) begin
            for (int b = 0; b < 4; b++)
              if (!TBL[i].bsel_n[b])
                ref_mem[TBL[i].addr][b*8 +: 8] = TBL[i].wd[b*8 +: 8];
          end else exp_data[i] = ref_mem[TBL[i].addr];
        end
      end else set_op(1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
    end

    // Sleep: accesses dropped, contents kept (R8)
    oe_n_i = 1'b0;
    @(negedge clk);
    set_op(1'b0, 1'b0, 1'b1, 4'hF, 6'd7, 32'hCAFE_F00D);
    @(negedge clk);
    sleep_i = 1'b1;
    set_op(1'b0, 1'b0, 1'b1, 4'hF, 6'd7, 32'hDEAD_BEEF);
    @(negedge clk);
    set_op(1'b0, 1'b1, 1'b1, 4'hF, 6'd7, 32'h0);
    @(negedge clk);
    #1;
    check("R8 sleep valid low a", {31'b0, rvalid_o}, 32'h0);
    @(negedge clk);
    #1;
    check("R8 sleep read ignored", {31'b0, rvalid_o}, 32'h0);
    sleep_i = 1'b0;
    set_op(1'b0, 1'b1, 1'b1, 4'hF, 6'd7, 32'h0);
    @(negedge clk);
    set_op(1'b0, 1'b1, 1'b1, 4'hF, 6'd7, 32'h0);
    @(negedge clk);
    #1;
    check("R8 valid after wake", {31'b0, rvalid_o}, 32'h1);
    check("R8 contents kept", rdata_o, 32'hCAFE_F00D);
    check("R7 no mask after sleep", {31'b0, drive_o}, 32'h1);

    // Reset mid-run: outputs cleared, deselected state, memory kept (R9, R7)
    rst = 1'b1;
    set_op(1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
    repeat (2) @(negedge clk);
    #1;
    check("R9 rst rvalid", {31'b0, rvalid_o}, 32'h0);
    check("R9 rst rdata", rdata_o, 32'h0);
    rst = 1'b0;
    set_op(1'b0, 1'b1, 1'b1, 4'hF, 6'd7, 32'h0);
    @(negedge clk);
    set_op(1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0);
    @(negedge clk);
    set_op(1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
    #1;
    check("R7 first read after reset valid", {31'b0, rvalid_o}, 32'h1);
    check("R7 first read after reset masked", {31'b0, drive_o}, 32'h0);
    check("R9 memory kept over reset", rdata_o, 32'hCAFE_F00D);
    @(negedge clk);
    #1;
    check("R7 second read drives", {31'b0, drive_o}, 32'h1);
    check("R3 merged word", rdata_o, 32'hFF34_DD78);
    oe_n_i = 1'b1;
    #1;
    check("R6 async oe release", {31'b0, drive_o}, 32'h0);
    @(negedge clk);
    finish_run();
  end
endmodule